// File: doc/BRIEF.md
# CCIR-656 Timing Reference Decoder

This block takes a byte-wide 4:2:2 component video stream in which timing is carried in-band. It finds the four-byte timing reference words in the stream and decodes the field, vertical-blank and end/start flags from each one. It passes the stream back out with a per-byte tag. The tag marks each byte as part of a reference word, as a blanking or ancillary byte, or as a Cb, Y or Cr sample of the active line. Ancillary data is not parsed. It is tagged as blanking.

Along the way the block counts the bytes between successive reference words. It raises a one-cycle length error when a blanking interval does not match the selected line system (525 or 625 lines), or when an active interval is not 1440 bytes long. Downstream logic uses `line_start`, `field` and `vblank` as its line and frame timing, and it uses `out_tag` to route samples.

The input side is valid/ready. The decoder never stalls, so `in_ready` is held high and there is no back-pressure: a byte is accepted in every cycle in which `in_valid` is high. The output side is valid-only. Because the decoder needs three bytes of look-ahead, a byte leaves the block three accepted bytes after it entered.

Top module: `ccir_trs_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_valid`, `line_start`, `len_err`, `field`, `vblank` and `out_active` are 0 and `out_tag` is 0 (blanking).
- R2: A reference word is four accepted bytes 0xFF, 0x00, 0x00, S with S[7]=1. S[6] is the field and S[5] is vertical blank. In the cycle after S is accepted, `field`=S[6] and `vblank`=S[5]. A fourth byte with S[7]=0 is not a reference word.
- R3: `line_start` is high for exactly one cycle, the cycle after accepting an S with S[4]=1 (end of active video). An S with S[4]=0 (start of active video) gives no pulse.
- R4: In the cycle after each accepted byte, `out_valid` is 1 and `out_data` carries the byte accepted three accepted bytes earlier. `out_valid` is 1 only from the fourth accepted byte after reset on. A cycle with `in_valid` low gives `out_valid`=0 in the next cycle and leaves `field` and `vblank` unchanged.
- R5: The four bytes of a reference word leave with `out_tag`=1.
- R6: The bytes that follow a start-of-active word leave tagged Cb (2), Y (3), Cr (4), Y (3), repeating, with `out_active`=1, until the 0xFF of the next end-of-active word.
- R7: Bytes that are neither in a reference word nor in the active interval leave with `out_tag`=0 and `out_active`=0.
- R8: Inside active video, an 0xFF that is not followed by 0x00 0x00 and a status byte with bit 7 set changes nothing: the tag sequence continues, and `line_start`, `len_err`, `field` and `vblank` keep their values.
- R9: On a start-of-active word, `len_err` pulses for one cycle if the bytes since the previous word's status byte (not counting the new word's 0xFF 0x00 0x00) number other than 268 with `sys_625`=0, or other than 280 with `sys_625`=1.
- R10: On an end-of-active word, `len_err` pulses if the active interval before it is not 1440 bytes. The first reference word after reset never flags an error.
- R11: `in_ready` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_625 | input | 1 | 0: 525-line system, 1: 625-line system |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always 1 |
| in_data | input | 8 | Multiplexed pixel byte |
| out_valid | output | 1 | Delayed byte valid |
| out_data | output | 8 | Byte accepted three bytes earlier |
| out_tag | output | 3 | 0 blank, 1 code, 2 Cb, 3 Y, 4 Cr |
| out_active | output | 1 | Output byte is an active sample |
| line_start | output | 1 | One-cycle pulse on end-of-active word |
| field | output | 1 | Field flag of the last word |
| vblank | output | 1 | Vertical-blank flag of the last word |
| len_err | output | 1 | One-cycle interval length error |

## Verification
The hardest case to reach from the ports is a near-miss reference word inside a full-length active line. A lone 0xFF, or an 0xFF 0x00 followed by a non-zero byte, or a correct prefix whose fourth byte has bit 7 clear, must neither end the line nor disturb the length count. The bench plants these patterns at fixed places in a 1440-byte active interval. It then closes the line with a real end-of-active word and checks the Cb/Y/Cr phase across the whole line. It also checks that no length error is raised. Length errors in both directions are produced by table lines with a short active interval and with a blanking length that does not match the selected system.

// File: rtl/ccir_trs_pkg.sv
package ccir_trs_pkg;
  typedef enum logic [2:0] {
    TAG_BLANK = 3'd0,
    TAG_CODE  = 3'd1,
    TAG_CB    = 3'd2,
    TAG_Y     = 3'd3,
    TAG_CR    = 3'd4
  } byte_tag_e;

  function automatic byte_tag_e phase_tag(input logic [1:0] ph);
    case (ph)
      2'd0:    phase_tag = TAG_CB;
      2'd2:    phase_tag = TAG_CR;
      default: phase_tag = TAG_Y;
    endcase
  endfunction
endpackage

// File: rtl/trs_window.sv
module trs_window #(
  parameter int DW      = 8,
  parameter int PRE_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          hit,
  output logic          old_valid,
  output logic [DW-1:0] old_data
);
  logic [DW-1:0] hist [PRE_LEN];
  logic [PRE_LEN-1:0] hv;

  always_ff @(posedge clk) begin
    if (!rst_n) hv <= '0;
    else if (in_valid) hv <= {hv[PRE_LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (in_valid) hist[0] <= in_data;
  end

  for (genvar i = 1; i < PRE_LEN; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (in_valid) hist[i] <= hist[i-1];
    end
  end

  // Oldest held byte must be 0xFF, the rest 0x00, and the new byte a status byte.
  logic prefix_ok;
  always_comb begin
    prefix_ok = (hist[PRE_LEN-1] == {DW{1'b1}});
    for (int k = 0; k < PRE_LEN-1; k++)
      if (hist[k] != '0) prefix_ok = 1'b0;
  end

  assign hit       = in_valid && hv[PRE_LEN-1] && prefix_ok && in_data[DW-1];
  assign old_valid = in_valid && hv[PRE_LEN-1];
  assign old_data  = hist[PRE_LEN-1];
endmodule

// File: rtl/byte_tagger.sv
module byte_tagger
  import ccir_trs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CODE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          old_valid,
  input  logic [DW-1:0] old_data,
  input  logic          hit,
  input  logic          is_eav,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output byte_tag_e     out_tag
);
  localparam int LW = $clog2(CODE_LEN);

  logic [LW-1:0] code_left;
  logic          pend_act;
  logic          act;
  logic [1:0]    phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= TAG_BLANK;
      code_left <= '0;
      pend_act  <= 1'b0;
      act       <= 1'b0;
      phase     <= '0;
    end else begin
      out_valid <= old_valid;
      if (old_valid) begin
        out_data <= old_data;
        if (hit) begin
          out_tag   <= TAG_CODE;
          code_left <= LW'(CODE_LEN-1);
          pend_act  <= ~is_eav;
          act       <= 1'b0;
        end else if (code_left != '0) begin
          out_tag   <= TAG_CODE;
          code_left <= code_left - 1'b1;
          if (code_left == LW'(1) && pend_act) begin
            act      <= 1'b1;
            phase    <= '0;
            pend_act <= 1'b0;
          end
        end else if (act) begin
          out_tag <= phase_tag(phase);
          phase   <= phase + 1'b1;
        end else begin
          out_tag <= TAG_BLANK;
        end
      end
    end
  end
endmodule

// File: rtl/gap_checker.sv
module gap_checker #(
  parameter int ACTIVE_LEN = 1440,
  parameter int BLANK_525  = 268,
  parameter int BLANK_625  = 280,
  parameter int PRE_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic hit,
  input  logic is_eav,
  input  logic sys_625,
  output logic len_err
);
  localparam int MAXLEN = ACTIVE_LEN + BLANK_625 + BLANK_525 + 2*PRE_LEN;
  localparam int CW     = $clog2(MAXLEN + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic          seen;
  logic [CW-1:0] gap;
  logic [CW-1:0] want;

  assign gap  = cnt - CW'(PRE_LEN);
  assign want = is_eav  ? CW'(ACTIVE_LEN) :
                sys_625 ? CW'(BLANK_625) : CW'(BLANK_525);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      seen    <= 1'b0;
      len_err <= 1'b0;
    end else begin
      len_err <= 1'b0;
      if (in_valid) begin
        if (hit) begin
          cnt     <= '0;
          seen    <= 1'b1;
          len_err <= seen && (gap != want);
        end else if (cnt != CMAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccir_trs_decoder.sv
module ccir_trs_decoder
  import ccir_trs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ACTIVE_LEN = 1440,
  parameter int BLANK_525  = 268,
  parameter int BLANK_625  = 280
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_625,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [2:0]    out_tag,
  output logic          out_active,
  output logic          line_start,
  output logic          field,
  output logic          vblank,
  output logic          len_err
);
  localparam int PRE_LEN = 3;
  localparam int F_BIT   = DW - 2;
  localparam int V_BIT   = DW - 3;
  localparam int H_BIT   = DW - 4;

  logic          hit;
  logic          old_valid;
  logic [DW-1:0] old_data;
  logic          is_eav;
  byte_tag_e     tag;

  assign in_ready = 1'b1;
  assign is_eav   = in_data[H_BIT];

  trs_window #(.DW(DW), .PRE_LEN(PRE_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .hit(hit), .old_valid(old_valid), .old_data(old_data)
  );

  byte_tagger #(.DW(DW), .CODE_LEN(PRE_LEN+1)) u_tag (
    .clk(clk), .rst_n(rst_n), .old_valid(old_valid), .old_data(old_data),
    .hit(hit), .is_eav(is_eav),
    .out_valid(out_valid), .out_data(out_data), .out_tag(tag)
  );

  gap_checker #(.ACTIVE_LEN(ACTIVE_LEN), .BLANK_525(BLANK_525),
                .BLANK_625(BLANK_625), .PRE_LEN(PRE_LEN)) u_gap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit),
    .is_eav(is_eav), .sys_625(sys_625), .len_err(len_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field      <= 1'b0;
      vblank     <= 1'b0;
      line_start <= 1'b0;
    end else begin
      line_start <= 1'b0;
      if (hit) begin
        field      <= in_data[F_BIT];
        vblank     <= in_data[V_BIT];
        line_start <= in_data[H_BIT];
      end
    end
  end

  assign out_tag    = tag;
  assign out_active = out_valid && (tag == TAG_CB || tag == TAG_Y || tag == TAG_CR);
endmodule

// File: rtl/ccir_trs_checker.sv
module ccir_trs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [2:0] out_tag,
  input logic       line_start,
  input logic       field,
  input logic       len_err
);
  logic [2:0] last_act;

  always_ff @(posedge clk) begin
    if (!rst_n) last_act <= 3'd0;
    else if (out_valid && out_tag >= 3'd2) last_act <= out_tag;
  end

  // R3: line marker is a single-cycle pulse
  a_r3_line_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  // R4: output only follows an accepted input byte
  a_r4_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R4: field holds across idle input cycles
  a_r4_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(field));

  // R6: a Cr sample is always preceded by a Y sample
  a_r6_cr_after_y: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == 3'd4) |-> last_act == 3'd3);

  // R9: a length error only follows an accepted byte
  a_r9_err_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(in_valid));
endmodule

bind ccir_trs_decoder ccir_trs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_tag(out_tag), .line_start(line_start), .field(field), .len_err(len_err)
);

// File: tb/tb_ccir_trs_decoder.sv
module tb_ccir_trs_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_625 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic [7:0] out_data;
  logic [2:0] out_tag;
  logic       out_active;
  logic       line_start;
  logic       field;
  logic       vblank;
  logic       len_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [10:0] expq[$];   // {tag, data}
  logic        exp_field = 1'b0;
  logic        exp_vblank = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccir_trs_decoder dut (
    .clk(clk), .rst_n(rst_n), .sys_625(sys_625), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_tag(out_tag), .out_active(out_active),
    .line_start(line_start), .field(field), .vblank(vblank), .len_err(len_err)
  );

  // {sys_625, field, vblank, blank_len[8:0], active_len[10:0]}
  localparam logic [22:0] VEC [5] = '{
    {1'b0, 1'b0, 1'b0, 9'd268, 11'd1440},
    {1'b1, 1'b1, 1'b0, 9'd280, 11'd1440},
    {1'b0, 1'b0, 1'b1, 9'd280, 11'd1440},
    {1'b1, 1'b1, 1'b1, 9'd280, 11'd1436},
    {1'b0, 1'b1, 1'b0, 9'd268, 11'd1440}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Drive one byte, let it be captured, sample at the following falling edge.
  task automatic send(input logic [7:0] b, input logic [2:0] tag,
                      input bit is_stat, input bit exp_ls, input bit exp_err);
    logic [10:0] e;
    in_valid = 1'b1;
    in_data  = b;
    expq.push_back({tag, b});
    @(negedge clk);
    if (expq.size() > 3) begin
      e = expq.pop_front();
      chk(out_valid == 1'b1, "R4 out_valid", int'(out_valid), 1);
      chk(out_data == e[7:0], "R4 out_data", int'(out_data), int'(e[7:0]));
      chk(out_tag == e[10:8], "R5/R6/R7 out_tag", int'(out_tag), int'(e[10:8]));
      chk(out_active == (e[10:8] >= 3'd2), "R6 out_active", int'(out_active),
          int'(e[10:8] >= 3'd2));
    end else begin
      chk(out_valid == 1'b0, "R4 fill", int'(out_valid), 0);
    end
    if (is_stat) begin
      chk(line_start == exp_ls, "R3 line_start", int'(line_start), int'(exp_ls));
      chk(len_err == exp_err, "R9/R10 len_err", int'(len_err), int'(exp_err));
    end else begin
      chk(line_start == 1'b0, "R3/R8 no line_start", int'(line_start), 0);
      chk(len_err == 1'b0, "R8 no len_err", int'(len_err), 0);
    end
    chk(field == exp_field, "R2/R8 field", int'(field), int'(exp_field));
    chk(vblank == exp_vblank, "R2/R8 vblank", int'(vblank), int'(exp_vblank));
    chk(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
  endtask

  task automatic send_code(input logic f, input logic v, input logic h, input bit err);
    send(8'hFF, 3'd1, 1'b0, 1'b0, 1'b0);
    send(8'h00, 3'd1, 1'b0, 1'b0, 1'b0);
    send(8'h00, 3'd1, 1'b0, 1'b0, 1'b0);
    exp_field  = f;
    exp_vblank = v;
    send(stat(f, v, h), 3'd1, 1'b1, h, err);
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 idle out_valid", int'(out_valid), 0);
    chk(field == exp_field, "R4 idle field", int'(field), int'(exp_field));
  endtask

  task automatic send_blank(input int n, input bit with_idle);
    for (int i = 0; i < n; i++) begin
      send((i % 2 == 0) ? 8'h80 : 8'h10, 3'd0, 1'b0, 1'b0, 1'b0);
      if (with_idle && i == 10) idle_cycle();
    end
  endtask

  task automatic send_active(input int n, input bit fakes);
    logic [7:0] b;
    logic [2:0] t;
    for (int i = 0; i < n; i++) begin
      t = (i % 4 == 0) ? 3'd2 : (i % 4 == 2) ? 3'd4 : 3'd3;
      b = 8'h20 + 8'(i % 64);
      if (fakes) begin
        // R8: near-miss codes inside active video
        if (i == 100) b = 8'hFF;
        if (i == 101) b = 8'h10;
        if (i == 300) b = 8'hFF;
        if (i == 301) b = 8'h00;
        if (i == 302) b = 8'h80;
        if (i == 500) b = 8'hFF;
        if (i == 501) b = 8'h00;
        if (i == 502) b = 8'h00;
        if (i == 503) b = 8'h10;
      end
      send(b, t, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expq.delete();
    exp_field = 1'b0;
    exp_vblank = 1'b0;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_tag == 3'd0, "R1 out_tag", int'(out_tag), 0);
    chk(line_start == 1'b0, "R1 line_start", int'(line_start), 0);
    chk(len_err == 1'b0, "R1 len_err", int'(len_err), 0);
    chk(field == 1'b0 && vblank == 1'b0, "R1 field/vblank", int'({field, vblank}), 0);
    chk(out_active == 1'b0, "R1 out_active", int'(out_active), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && len_err == 1'b0, "R1 after release",
        int'({out_valid, len_err}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int prev_act;
    bit first;
    do_reset();

    // Table of lines: R2, R3, R5-R7, R9, R10
    first = 1'b1;
    prev_act = 1440;
    foreach (VEC[k]) begin
      sys_625 = VEC[k][22];
      send_code(VEC[k][21], VEC[k][20], 1'b1, !first && prev_act != 1440);
      first = 1'b0;
      send_blank(int'(VEC[k][19:11]), k == 1);
      send_code(VEC[k][21], VEC[k][20], 1'b0,
                int'(VEC[k][19:11]) != (VEC[k][22] ? 280 : 268));
      send_active(int'(VEC[k][10:0]), 1'b0);
      prev_act = int'(VEC[k][10:0]);
    end
    send_code(1'b0, 1'b0, 1'b1, prev_act != 1440);

    // Directed R8: near-miss codes inside a correct 625-line line
    sys_625 = 1'b1;
    send_blank(280, 1'b0);
    send_code(1'b0, 1'b0, 1'b0, 1'b0);
    send_active(1440, 1'b1);
    send_code(1'b1, 1'b1, 1'b1, 1'b0);

    // R2: prefix with bit 7 clear in blanking is not a code
    send(8'hFF, 3'd0, 1'b0, 1'b0, 1'b0);
    send(8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    send(8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
    send(8'h70, 3'd0, 1'b0, 1'b0, 1'b0);
    send_blank(276, 1'b0);
    send_code(1'b1, 1'b1, 1'b0, 1'b0);

    // R1/R10: reset mid-stream, first code after reset never flags
    do_reset();
    sys_625 = 1'b0;
    send_blank(5, 1'b0);
    send_code(1'b1, 1'b0, 1'b0, 1'b0);
    send_active(8, 1'b0);
    send_code(1'b0, 1'b0, 1'b1, 1'b1);
    send_blank(4, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule